// File: doc/BRIEF.md
# Six-Pin General Purpose I/O Port

This block is the digital side of a small microcontroller's six-pin I/O port. Software reaches it through a simple register bus. It can set the direction of each pin, drive an output latch, read back either the held latch or the live pin level, mask the digital input of pins used for analog, and turn on weak pull-ups. The pad side gives a value, an output enable and a pull-up enable for each pin. It takes the raw pin levels and passes them through a two-flop synchronizer.

Four peripheral functions can take control of a pin. Each function has two candidate pins, and a steering register picks one of them. While a function is enabled, its output value and output enable replace the GPIO drive on the selected pin. The other candidate pin stays under normal GPIO control. Steering never changes the direction register. Every function always receives the synchronized, analog-gated level of its selected pin.

The register bus and the peripheral signals are plain control signals with no handshake. A read returns its data on the cycle after the read strobe.

Top module: `gpio_port`

## Requirements
- R1: After reset, DIR (addr 0) reads 0x3F, LAT (addr 2) reads 0x00, ANA (addr 3) reads 0x3F, PULL (addr 4) reads 0x00 and ALT (addr 5) reads 0x00. After reset, pad_oe and pad_pu are 0.
- R2: A write to either the PIN address (1) or the LAT address (2) stores wr_data[5:0] into the one output latch. A read of LAT returns that latch.
- R3: A read of PIN (addr 1) returns pad_in after a two-stage synchronizer. A pin change driven before edge k is returned by a read whose strobe is sampled at edge k+2 or later. A read sampled at edge k+1 still returns the old level.
- R4: A pin whose ANA bit is 1 reads 0 in the PIN register and gives 0 on periph_in.
- R5: On a pin that no function owns, pad_oe equals the inverse of its DIR bit (1 = input). On every pin that no function owns, pad_out carries its latch bit.
- R6: pad_pu[p] is PULL[p] AND NOT pad_oe[p], so a pull-up is applied only when the pin is not driven.
- R7: When periph_en[f] is 1, pad_out and pad_oe of the pin selected for function f equal periph_out[f] and periph_oe[f].
- R8: ALT bit f chooses the pin for function f: 0 selects the primary pin and 1 the alternate. The pin pairs are f0: 0/4, f1: 1/5, f2: 2/3 and f3: 4/3. The candidate pin that is not selected returns to GPIO control. Writing ALT leaves DIR unchanged.
- R9: When two enabled functions select the same pin, the lower function index owns it.
- R10: periph_in[f] equals the synchronized, analog-gated level of the pin selected for function f, whether or not the function is enabled.
- R11: Addresses 6 and 7 read as 0 and ignore writes. Read bits 7:6 are always 0.
- R12: rd_data is registered. It holds the addressed value on the cycle after rd_en is sampled and is 0 on cycles after rd_en was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 8 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 8 | Read data, one cycle after the strobe |
| pad_in | input | 6 | Raw pin levels |
| pad_out | output | 6 | Pin drive value |
| pad_oe | output | 6 | Pin output enable |
| pad_pu | output | 6 | Weak pull-up enable |
| periph_en | input | 4 | Function takes its selected pin |
| periph_out | input | 4 | Function output value |
| periph_oe | input | 4 | Function output enable |
| periph_in | output | 4 | Level of each function's selected pin |

## Verification
The bench targets the split between the two read paths. A design that routed the pin register to the latch, or the latch read to the pins, would fail the sweeps in which the latch and the driven pin levels differ. It probes the synchronizer depth with a read issued one cycle after a pin change. A single flop would return the new level there, and a missing synchronizer would fail earlier still. It runs every steering and enable combination against a computed ownership model. That catches a steering write that disturbs the direction bits, an unselected pin that stays captured, and a reversed priority on the shared pins 3 and 4. Analog masks and out-of-range addresses are swept to show that the digital reads are gated and that stray writes are dropped.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_PIN  = 3'd1,
    REG_LAT  = 3'd2,
    REG_ANA  = 3'd3,
    REG_PULL = 3'd4,
    REG_ALT  = 3'd5
  } reg_addr_e;

  // Candidate pin pairs, function 3 in the top field down to function 0.
  localparam logic [11:0] PRI_PINS_D = {3'd4, 3'd2, 3'd1, 3'd0};
  localparam logic [11:0] ALT_PINS_D = {3'd3, 3'd3, 3'd5, 3'd4};
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPIN  = 6,
  parameter int NFUNC = 4,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic [NPIN-1:0]   pin_lvl,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   lat_q,
  output logic [NPIN-1:0]   ana_q,
  output logic [NPIN-1:0]   pull_q,
  output logic [NFUNC-1:0]  alt_q
);
  logic [DW-1:0] rd_mux;
  logic          unused_hi;

  assign unused_hi = ^wr_data[DW-1:NPIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      lat_q  <= '0;
      ana_q  <= '1;
      pull_q <= '0;
      alt_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DIR:           dir_q  <= wr_data[NPIN-1:0];
        REG_PIN, REG_LAT:  lat_q  <= wr_data[NPIN-1:0];
        REG_ANA:           ana_q  <= wr_data[NPIN-1:0];
        REG_PULL:          pull_q <= wr_data[NPIN-1:0];
        REG_ALT:           alt_q  <= wr_data[NFUNC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_DIR:  rd_mux[NPIN-1:0]  = dir_q;
      REG_PIN:  rd_mux[NPIN-1:0]  = pin_lvl;
      REG_LAT:  rd_mux[NPIN-1:0]  = lat_q;
      REG_ANA:  rd_mux[NPIN-1:0]  = ana_q;
      REG_PULL: rd_mux[NPIN-1:0]  = pull_q;
      REG_ALT:  rd_mux[NFUNC-1:0] = alt_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int NPIN  = 6,
  parameter int NFUNC = 4,
  parameter int PW    = $clog2(NPIN),
  parameter logic [NFUNC*PW-1:0] PRI_PINS = '0,
  parameter logic [NFUNC*PW-1:0] ALT_PINS = '0
) (
  input  logic [NPIN-1:0]  dir_q,
  input  logic [NPIN-1:0]  lat_q,
  input  logic [NPIN-1:0]  pull_q,
  input  logic [NFUNC-1:0] alt_q,
  input  logic [NPIN-1:0]  dig_in,
  input  logic [NFUNC-1:0] periph_en,
  input  logic [NFUNC-1:0] periph_out,
  input  logic [NFUNC-1:0] periph_oe,
  output logic [NPIN-1:0]  pad_out,
  output logic [NPIN-1:0]  pad_oe,
  output logic [NPIN-1:0]  pad_pu,
  output logic [NFUNC-1:0] periph_in
);
  localparam int FW = (NFUNC > 1) ? $clog2(NFUNC) : 1;

  logic [PW-1:0] sel_pin [NFUNC];

  for (genvar f = 0; f < NFUNC; f++) begin : g_func
    assign sel_pin[f]   = alt_q[f] ? ALT_PINS[f*PW +: PW] : PRI_PINS[f*PW +: PW];
    assign periph_in[f] = dig_in[sel_pin[f]];
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic          own_vld;
    logic [FW-1:0] own_idx;

    always_comb begin
      own_vld = 1'b0;
      own_idx = '0;
      for (int f = NFUNC-1; f >= 0; f--) begin
        if (periph_en[f] && sel_pin[f] == PW'(p)) begin
          own_vld = 1'b1;
          own_idx = FW'(f);
        end
      end
    end

    assign pad_out[p] = own_vld ? periph_out[own_idx] : lat_q[p];
    assign pad_oe[p]  = own_vld ? periph_oe[own_idx]  : ~dir_q[p];
    assign pad_pu[p]  = pull_q[p] & ~pad_oe[p];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NPIN        = 6,
  parameter int NFUNC       = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PW          = $clog2(NPIN),
  parameter logic [NFUNC*PW-1:0] PRI_PINS = PRI_PINS_D,
  parameter logic [NFUNC*PW-1:0] ALT_PINS = ALT_PINS_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DW-1:0]     bus_wr_data,
  input  logic              bus_rd_en,
  output logic [DW-1:0]     bus_rd_data,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu,
  input  logic [NFUNC-1:0]  periph_en,
  input  logic [NFUNC-1:0]  periph_out,
  input  logic [NFUNC-1:0]  periph_oe,
  output logic [NFUNC-1:0]  periph_in
);
  logic [NPIN-1:0]  sync_lvl;
  logic [NPIN-1:0]  dig_in;
  logic [NPIN-1:0]  dir_q;
  logic [NPIN-1:0]  lat_q;
  logic [NPIN-1:0]  ana_q;
  logic [NPIN-1:0]  pull_q;
  logic [NFUNC-1:0] alt_q;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_lvl)
  );

  assign dig_in = sync_lvl & ~ana_q;

  gpio_regs #(.NPIN(NPIN), .NFUNC(NFUNC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
    .wr_data(bus_wr_data), .rd_en(bus_rd_en), .rd_data(bus_rd_data),
    .pin_lvl(dig_in), .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q),
    .pull_q(pull_q), .alt_q(alt_q)
  );

  gpio_pinmux #(
    .NPIN(NPIN), .NFUNC(NFUNC), .PW(PW),
    .PRI_PINS(PRI_PINS), .ALT_PINS(ALT_PINS)
  ) u_mux (
    .dir_q(dir_q), .lat_q(lat_q), .pull_q(pull_q), .alt_q(alt_q),
    .dig_in(dig_in), .periph_en(periph_en), .periph_out(periph_out),
    .periph_oe(periph_oe), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .periph_in(periph_in)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int NPIN = 6,
  parameter int DW   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [DW-1:0]     bus_wr_data,
  input logic              bus_rd_en,
  input logic [DW-1:0]     bus_rd_data,
  input logic [NPIN-1:0]   pad_oe,
  input logic [NPIN-1:0]   pad_pu,
  input logic [NPIN-1:0]   dir_q,
  input logic [NPIN-1:0]   lat_q,
  input logic [NPIN-1:0]   ana_q
);
  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && (bus_addr == REG_PIN || bus_addr == REG_LAT)
    |=> lat_q == $past(bus_wr_data[NPIN-1:0]));

  assert_analog_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd_en) && $past(bus_addr) == REG_PIN
    |-> (bus_rd_data[NPIN-1:0] & $past(ana_q)) == '0);

  assert_pullup_not_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  assert_alt_keeps_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en && bus_addr == REG_ALT |=> $stable(dir_q));

  assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd_en) |-> bus_rd_data == '0);
endmodule

bind gpio_port gpio_port_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
  .pad_oe(pad_oe), .pad_pu(pad_pu), .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q)
);

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
  localparam logic [2:0] A_DIR = 3'd0, A_PIN = 3'd1, A_LAT = 3'd2,
                         A_ANA = 3'd3, A_PULL = 3'd4, A_ALT = 3'd5;
  localparam int PRI [4] = '{0, 1, 2, 4};
  localparam int ALT [4] = '{4, 5, 3, 3};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wr_data = '0;
  logic       bus_rd_en = 1'b0;
  logic [7:0] bus_rd_data;
  logic [5:0] pad_in = '0;
  logic [5:0] pad_out, pad_oe, pad_pu;
  logic [3:0] periph_en = '0, periph_out = '0, periph_oe = '0;
  logic [3:0] periph_in;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .periph_en(periph_en), .periph_out(periph_out), .periph_oe(periph_oe),
    .periph_in(periph_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  function automatic int sel(input int f, input logic [3:0] alt);
    return alt[f] ? ALT[f] : PRI[f];
  endfunction

  // Expected pad vectors {pu, oe, out} from the ownership rules.
  function automatic logic [17:0] pads(input logic [5:0] dir, input logic [5:0] lat,
      input logic [5:0] pull, input logic [3:0] alt, input logic [3:0] en,
      input logic [3:0] po, input logic [3:0] poe);
    logic [5:0] o, e, u;
    for (int p = 0; p < 6; p++) begin
      int own = -1;
      for (int f = 3; f >= 0; f--) if (en[f] && sel(f, alt) == p) own = f;
      o[p] = (own >= 0) ? po[own]  : lat[p];
      e[p] = (own >= 0) ? poe[own] : ~dir[p];
      u[p] = pull[p] & ~e[p];
    end
    return {u, e, o};
  endfunction

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_pu", 32'(pad_pu), 0);
    rd(A_DIR, v);  chk("R1 DIR", 32'(v), 32'h3F);
    rd(A_LAT, v);  chk("R1 LAT", 32'(v), 0);
    rd(A_ANA, v);  chk("R1 ANA", 32'(v), 32'h3F);
    rd(A_PULL, v); chk("R1 PULL", 32'(v), 0);
    rd(A_ALT, v);  chk("R1 ALT", 32'(v), 0);
    chk("R12 idle rd_data", 32'(bus_rd_data), 0);

    // R11 unmapped addresses
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd6, v); chk("R11 addr6", 32'(v), 0);
    rd(3'd7, v); chk("R11 addr7", 32'(v), 0);
    rd(A_DIR, v); chk("R11 DIR untouched", 32'(v), 32'h3F);
    rd(A_LAT, v); chk("R11 LAT untouched", 32'(v), 0);

    // R2 latch via both addresses, upper bits dropped (R11)
    for (int i = 0; i < 64; i++) begin
      wr((i % 2) ? A_PIN : A_LAT, 8'(i) | 8'hC0);
      rd(A_LAT, v);
      chk("R2 LAT readback", 32'(v), 32'(i));
    end

    // R5 direction sweep
    wr(A_ANA, 8'h00);
    for (int i = 0; i < 64; i++) begin
      wr(A_DIR, 8'(i));
      wr(A_LAT, 8'(~i & 6'h3F));
      chk("R5 pad_oe", 32'(pad_oe), 32'(~i & 6'h3F));
      chk("R5 pad_out", 32'(pad_out), 32'(~i & 6'h3F));
    end

    // R6 pull-up sweep with pins 4,5 input
    wr(A_DIR, 8'h30);
    for (int i = 0; i < 64; i++) begin
      wr(A_PULL, 8'(i));
      chk("R6 pad_pu", 32'(pad_pu), 32'(i & 6'h30));
    end
    wr(A_PULL, 8'h00);

    // R3 pin read vs latch
    wr(A_DIR, 8'h3F); wr(A_LAT, 8'h2A);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); pad_in = 6'(i);
      repeat (2) @(negedge clk);
      rd(A_PIN, v); chk("R3 PIN level", 32'(v), 32'(i));
    end
    rd(A_LAT, v); chk("R3 LAT holds latch", 32'(v), 32'h2A);

    // R3 synchronizer depth: read sampled one edge after change is old
    @(negedge clk); pad_in = 6'h15;
    @(negedge clk); bus_addr = A_PIN; bus_rd_en = 1'b1;
    @(negedge clk); bus_rd_en = 1'b0;
    chk("R3 one-edge read old", 32'(bus_rd_data), 32'h3F);
    rd(A_PIN, v); chk("R3 two-edge read new", 32'(v), 32'h15);

    // R4 analog gating
    @(negedge clk); pad_in = 6'h3F;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      wr(A_ANA, 8'(i));
      rd(A_PIN, v); chk("R4 PIN gated", 32'(v), 32'(~i & 6'h3F));
      chk("R4 periph_in f0", 32'(periph_in[0]), 32'(~i & 1));
    end
    wr(A_ANA, 8'h00);

    // R7 R8 R9 ownership sweep
    wr(A_DIR, 8'h2A); wr(A_LAT, 8'h33); wr(A_PULL, 8'h3F);
    periph_out = 4'b0101; periph_oe = 4'b1011;
    for (int a = 0; a < 16; a++) begin
      wr(A_ALT, 8'(a));
      rd(A_DIR, v); chk("R8 DIR kept after ALT", 32'(v), 32'h2A);
      rd(A_ALT, v); chk("R8 ALT readback", 32'(v), 32'(a));
      for (int e = 0; e < 16; e++) begin
        @(negedge clk); periph_en = 4'(e);
        #1;
        chk("R7 R9 pads", 32'({pad_pu, pad_oe, pad_out}),
            32'(pads(6'h2A, 6'h33, 6'h3F, 4'(a), 4'(e), periph_out, periph_oe)));
      end
    end
    periph_en = '0;

    // R10 periph_in follows the selected pin
    @(negedge clk); pad_in = 6'b011010;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      wr(A_ALT, 8'(a));
      for (int f = 0; f < 4; f++)
        chk("R10 periph_in", 32'(periph_in[f]), 32'(pad_in[sel(f, 4'(a))]));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule